// File: doc/BRIEF.md
# Input-Triggered Pulse Burst Generator

This block is a small Moore state machine that watches a two-bit input code while it is at rest and answers with a short burst of high output cycles. The length of the burst is selected by the code: one pattern asks for a single high cycle, another asks for two high cycles back to back. Codes whose two bits are equal leave the machine at rest.

Once a burst has started, the machine ignores its inputs until the burst is over. Only then does it look at the code again. The output comes from a register that is updated from the next state, so it never depends combinationally on the inputs. A burst therefore shows on the output in the cycle after its code was sampled. The machine re-arms in the same cycle that the output falls, which lets a burst follow the previous one with a single low cycle between them.

Top module: `pulse_burst_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine goes to rest, and `z` is 0 after that edge. Reset is synchronous and active high.
- R2: At rest, a sampled code {`x2`,`x1`} of 2'b00 or 2'b11 keeps the machine at rest, and `z` stays 0.
- R3: At rest, a sampled code of 2'b01 (`x2`=0, `x1`=1) makes `z` 1 for exactly one cycle, starting at the next edge. `z` then returns to 0 and the machine is at rest.
- R4: At rest, a sampled code of 2'b10 (`x2`=1, `x1`=0) makes `z` 1 for exactly two consecutive cycles, starting at the next edge. `z` then returns to 0 and the machine is at rest.
- R5: The cycle in which `z` has returned to 0 is a rest cycle whose code is sampled. A trigger code present then starts a new burst at the next edge.
- R6: Input values sampled while a burst is in progress (`z` = 1) have no effect on the length or timing of that burst.
- R7: `z` is a function of the state register only, and the internal state encodings that are not used fall back to rest at the next edge.
- R8: A reset asserted in the middle of a burst ends it: `z` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x2 | input | 1 | Upper bit of the trigger code |
| x1 | input | 1 | Lower bit of the trigger code |
| z | output | 1 | Registered burst output |

## Verification
A wrong internal state shows up at `z` within one or two edges. A stuck or skipped state shortens or stretches a burst by one cycle. A failure to re-arm drops the burst that should follow at once. Inputs leaking into a busy state change the burst length. For this reason the bench compares `z` on every clock against a counter-based model, using directed codes placed at the burst boundaries and a long random stream.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_SINGLE = 2'b01;
    localparam logic [CODE_W-1:0] CODE_DOUBLE = 2'b10;

    typedef enum logic [1:0] {
        ST_REST   = 2'b00,
        ST_SOLO   = 2'b01,
        ST_PAIR_A = 2'b10,
        ST_PAIR_B = 2'b11
    } pbg_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_ONE,
        REQ_TWO
    } pbg_req_e;

    function automatic pbg_req_e classify(input logic [CODE_W-1:0] code);
        if (code == CODE_SINGLE)      return REQ_ONE;
        else if (code == CODE_DOUBLE) return REQ_TWO;
        else                          return REQ_NONE;
    endfunction

endpackage

// File: rtl/pbg_code_decode.sv
module pbg_code_decode
    import pbg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output pbg_req_e          req
);
    always_comb begin
        req = classify(code);
    end
endmodule

// File: rtl/pbg_fsm.sv
module pbg_fsm
    import pbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pbg_req_e   req,
    output pbg_state_e state,
    output pbg_state_e state_nx
);
    always_comb begin
        case (state)
            ST_REST: begin
                case (req)
                    REQ_ONE: state_nx = ST_SOLO;
                    REQ_TWO: state_nx = ST_PAIR_A;
                    default: state_nx = ST_REST;
                endcase
            end
            ST_SOLO:   state_nx = ST_REST;
            ST_PAIR_A: state_nx = ST_PAIR_B;
            ST_PAIR_B: state_nx = ST_REST;
            default:   state_nx = ST_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_REST;
        else     state <= state_nx;
    end
endmodule

// File: rtl/pbg_out_reg.sv
module pbg_out_reg
    import pbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pbg_state_e state_nx,
    output logic       z
);
    always_ff @(posedge clk) begin
        if (rst) z <= 1'b0;
        else     z <= (state_nx != ST_REST);
    end
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
    import pbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x2,
    input  logic x1,
    output logic z
);
    pbg_req_e   req;
    pbg_state_e state;
    pbg_state_e state_nx;

    pbg_code_decode u_dec (
        .code ({x2, x1}),
        .req  (req)
    );

    pbg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .state    (state),
        .state_nx (state_nx)
    );

    pbg_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .state_nx (state_nx),
        .z        (z)
    );
endmodule

// File: rtl/pbg_chk.sv
module pbg_chk
    import pbg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x2,
    input logic       x1,
    input logic       z,
    input pbg_state_e state
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            reset_low_chk: assert (z == 1'b0);
        end
    end

    // R2
    equal_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST && x2 == x1) |=> (state == ST_REST && !z));

    // R3
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST && !x2 && x1) |=> (state == ST_SOLO && z));

    // R3
    single_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SOLO) |=> (state == ST_REST && !z));

    // R4
    double_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST && x2 && !x1) |=> (state == ST_PAIR_A && z));

    // R6
    double_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAIR_A) |=> (state == ST_PAIR_B && z));

    // R4
    double_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAIR_B) |=> (state == ST_REST && !z));

    // R7
    moore_out_chk: assert property (@(posedge clk) disable iff (rst)
        z == (state != ST_REST));
endmodule

bind pulse_burst_gen pbg_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .x2    (x2),
    .x1    (x1),
    .z     (z),
    .state (state)
);

// File: tb/sim_pulse_burst_gen.sv
`timescale 1ns/1ps
module sim_pulse_burst_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x2 = 1'b0;
    logic x1 = 1'b0;
    logic z;

    int checks = 0;
    int errors = 0;
    int remain = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pulse_burst_gen u0 (
        .clk (clk),
        .rst (rst),
        .x2  (x2),
        .x1  (x1),
        .z   (z)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: z actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input logic a2, input logic a1, input logic r, input string tag);
        x2 = a2; x1 = a1; rst = r;
        @(posedge clk);
        if (r) remain = 0;
        else if (remain == 0) begin
            if (!a2 && a1)      remain = 1;
            else if (a2 && !a1) remain = 2;
        end else remain--;
        @(negedge clk);
        check(z, remain > 0, tag);
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        cyc(0, 1, 1, "R1");
        cyc(1, 0, 1, "R1");
        // R2 equal codes hold
        cyc(0, 0, 0, "R2");
        cyc(1, 1, 0, "R2");
        cyc(1, 1, 0, "R2");
        // R3 single pulse
        cyc(0, 1, 0, "R3");
        cyc(0, 0, 0, "R3");
        cyc(0, 0, 0, "R3");
        // R4 double pulse
        cyc(1, 0, 0, "R4");
        cyc(0, 0, 0, "R4");
        cyc(0, 0, 0, "R4");
        cyc(0, 0, 0, "R4");
        // R5 immediate re-trigger
        cyc(0, 1, 0, "R5");
        cyc(1, 0, 0, "R5");
        cyc(1, 0, 0, "R5");
        cyc(0, 1, 0, "R5");
        cyc(0, 0, 0, "R5");
        cyc(0, 0, 0, "R5");
        // R6 inputs ignored during a burst
        cyc(0, 1, 0, "R6");
        cyc(1, 0, 0, "R6");
        cyc(1, 1, 0, "R6");
        cyc(1, 0, 0, "R6");
        cyc(1, 0, 0, "R6");
        cyc(0, 1, 0, "R6");
        cyc(1, 1, 0, "R6");
        cyc(0, 0, 0, "R6");
        // R8 reset mid-burst
        cyc(1, 0, 0, "R8");
        cyc(1, 0, 1, "R8");
        cyc(0, 0, 0, "R8");
        // R7 random stream against the model
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] rv;
            rv = 4'($urandom);
            cyc(rv[0], rv[1], (rv[3:2] == 2'b11) && (rv[0] ^ rv[1]) && (i % 37 == 0), "R7");
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule